// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

An 8-bit arithmetic and logic unit for a machine built around a single accumulator. On each accepted operation it reads the accumulator, a second byte, the current five status flags and a 4-bit operation code. It returns the new accumulator value and the new flags. The second byte can come from a register, from memory or from an immediate field. Instruction fetch, decode and operand selection belong to the surrounding core.

Each operation keeps its own rule for which flags it writes. The logic operations force carry low and give auxiliary carry a fixed value. Compare writes flags only. Complement writes no flag. The set-carry, invert-carry and rotate operations touch carry alone. Decimal adjust corrects a binary sum into two packed BCD digits.

The flags travel as a 5-bit vector with this bit order: bit 4 sign, bit 3 zero, bit 2 auxiliary carry, bit 1 parity, bit 0 carry. The result and flags are registered, so they appear on the clock edge that accepts the operation.

Top module: `acc_alu`

## Requirements
- R1: While `rst_n` is low, `res_out` is 00h, `flags_out` is 0 and `out_valid` is 0.
- R2: An edge with `in_valid` high loads `res_out` and `flags_out` and raises `out_valid` for the following cycle. An edge with `in_valid` low clears `out_valid` and holds `res_out` and `flags_out` unchanged.
- R3: For every operation that writes them, sign is result bit 7, zero is 1 when the result is 00h, and parity is 1 when the result has an even number of one bits.
- R4: Op 0 (add) returns A+B. Op 1 (add with carry) returns A+B+CY. Carry is the carry out of bit 7. Auxiliary carry is the carry out of bit 3.
- R5: Op 2 (subtract) returns A−B. Op 3 (subtract with borrow) returns A−B−CY. Carry is 1 on a borrow. Auxiliary carry is the carry out of the low nibble of A + ~B + (1 − borrow-in).
- R6: Op 4 (AND), op 5 (XOR) and op 6 (OR) clear carry. AND sets auxiliary carry; XOR and OR clear it.
- R7: Op 7 (compare) returns A unchanged. Its flags are those of A−B: A<B gives CY=1 Z=0, A=B gives CY=0 Z=1, and A>B gives CY=0 Z=0.
- R8: Op 8 (complement) returns ~A, and `flags_out` equals `flags_in`.
- R9: Op 9 sets carry and op 10 inverts carry. Both return A unchanged and keep the other four flags.
- R10: Op 11 rotates left and copies bit 7 into bit 0 and into CY. Op 12 rotates right and copies bit 0 into bit 7 and into CY. Op 13 rotates left through CY. Op 14 rotates right through CY. All four keep the other four flags.
- R11: Op 15 (decimal adjust) first adds 06h if the low nibble is above 9 or AC=1. It then adds 60h if the high nibble of that sum is above 9, the sum overflowed, or CY=1. CY is set when the 60h correction applies, and AC is the carry out of bit 3 of the first correction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Operation code |
| acc_in | input | 8 | Accumulator value |
| opnd_in | input | 8 | Second operand |
| flags_in | input | 5 | Current flags {S,Z,AC,P,CY} |
| res_out | output | 8 | New accumulator value |
| flags_out | output | 5 | New flags {S,Z,AC,P,CY} |
| out_valid | output | 1 | Result registered from the previous cycle |

## Verification
All results are due one clock edge after the operation is accepted. There is exactly one register between the inputs and `res_out`, `flags_out` and `out_valid`. The bench drives inputs on the falling edge and lets one rising edge pass. It samples on the next falling edge, then drops `in_valid`. For the hold checks it changes the inputs while `in_valid` is low, waits two edges, and confirms that the outputs have not moved.

// File: rtl/acc_alu.sv
module acc_alu (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [3:0] op,
  input  logic [7:0] acc_in,
  input  logic [7:0] opnd_in,
  input  logic [4:0] flags_in,
  output logic [7:0] res_out,
  output logic [4:0] flags_out,
  output logic       out_valid
);
  localparam logic [3:0] OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBB = 4'd3;
  localparam logic [3:0] OP_AND = 4'd4,  OP_XOR = 4'd5,  OP_OR  = 4'd6,  OP_CMP = 4'd7;
  localparam logic [3:0] OP_CMA = 4'd8,  OP_STC = 4'd9,  OP_CMC = 4'd10, OP_RLC = 4'd11;
  localparam logic [3:0] OP_RRC = 4'd12, OP_RAL = 4'd13, OP_RAR = 4'd14, OP_DAA = 4'd15;

  wire       cy     = flags_in[0];
  wire       ac     = flags_in[2];
  wire       is_sub = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
  wire [7:0] bx     = is_sub ? ~opnd_in : opnd_in;
  wire       cin    = is_sub ? ~((op == OP_SBB) & cy) : ((op == OP_ADC) & cy);
  wire [8:0] sum9   = {1'b0, acc_in} + {1'b0, bx} + {8'd0, cin};
  wire [4:0] nib    = {1'b0, acc_in[3:0]} + {1'b0, bx[3:0]} + {4'd0, cin};
  wire       ar_cy  = is_sub ? ~sum9[8] : sum9[8];

  wire       lo_fix = (acc_in[3:0] > 4'd9) | ac;
  wire [4:0] lo_nib = {1'b0, acc_in[3:0]} + (lo_fix ? 5'd6 : 5'd0);
  wire [8:0] t9     = {1'b0, acc_in} + (lo_fix ? 9'd6 : 9'd0);
  wire       hi_fix = (t9[7:4] > 4'd9) | t9[8] | cy;
  wire [7:0] daa_r  = t9[7:0] + (hi_fix ? 8'h60 : 8'h00);

  logic [7:0] r;
  logic [4:0] f;

  function automatic logic [4:0] szp(input logic [7:0] v, input logic a, input logic c);
    return {v[7], (v == 8'h00), a, ~^v, c};
  endfunction

  always_comb begin
    r = acc_in;
    f = flags_in;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
        r = sum9[7:0];
        f = szp(sum9[7:0], nib[4], ar_cy);
      end
      OP_CMP: f = szp(sum9[7:0], nib[4], ar_cy);
      OP_AND: begin r = acc_in & opnd_in; f = szp(r, 1'b1, 1'b0); end
      OP_XOR: begin r = acc_in ^ opnd_in; f = szp(r, 1'b0, 1'b0); end
      OP_OR:  begin r = acc_in | opnd_in; f = szp(r, 1'b0, 1'b0); end
      OP_CMA: r = ~acc_in;
      OP_STC: f[0] = 1'b1;
      OP_CMC: f[0] = ~cy;
      OP_RLC: begin r = {acc_in[6:0], acc_in[7]}; f[0] = acc_in[7]; end
      OP_RRC: begin r = {acc_in[0], acc_in[7:1]}; f[0] = acc_in[0]; end
      OP_RAL: begin r = {acc_in[6:0], cy};        f[0] = acc_in[7]; end
      OP_RAR: begin r = {cy, acc_in[7:1]};        f[0] = acc_in[0]; end
      OP_DAA: begin r = daa_r; f = szp(daa_r, lo_nib[4], hi_fix); end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_out   <= 8'h00;
      flags_out <= 5'd0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res_out   <= r;
        flags_out <= f;
      end
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(res_out) && $stable(flags_out)));
  // R6
  logic_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == OP_AND || op == OP_OR || op == OP_XOR)) |=> !flags_out[0]);
  // R7
  cmp_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_CMP) |=> (res_out == $past(acc_in)));
  // R8
  cma_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_CMA) |=> (flags_out == $past(flags_in)));
  // R10
  rot_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op >= OP_RLC && op <= OP_RAR) |=> (flags_out[4:1] == $past(flags_in[4:1])));
endmodule

// File: tb/tb_acc_alu.sv
module tb_acc_alu;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 21;

  // {op, acc, opnd, flags_in, expected result, expected flags}
  localparam logic [37:0] VEC [NV] = '{
    {4'd0,  8'h78, 8'h42, 5'h00, 8'hBA, 5'h10},
    {4'd15, 8'hBA, 8'h00, 5'h10, 8'h20, 5'h05},
    {4'd1,  8'hFF, 8'h00, 5'h01, 8'h00, 5'h0F},
    {4'd2,  8'h30, 8'h40, 5'h00, 8'hF0, 5'h17},
    {4'd3,  8'h10, 8'h05, 5'h01, 8'h0A, 5'h02},
    {4'd4,  8'hF0, 8'h3C, 5'h01, 8'h30, 5'h06},
    {4'd6,  8'h0F, 8'hF0, 5'h05, 8'hFF, 5'h12},
    {4'd5,  8'h5A, 8'h5A, 5'h11, 8'h00, 5'h0A},
    {4'd7,  8'h20, 8'h30, 5'h00, 8'h20, 5'h17},
    {4'd7,  8'h44, 8'h44, 5'h00, 8'h44, 5'h0E},
    {4'd7,  8'h50, 8'h20, 5'h01, 8'h50, 5'h06},
    {4'd8,  8'h3C, 8'h99, 5'h15, 8'hC3, 5'h15},
    {4'd9,  8'h12, 8'h00, 5'h0A, 8'h12, 5'h0B},
    {4'd10, 8'h12, 8'h00, 5'h0B, 8'h12, 5'h0A},
    {4'd10, 8'h12, 8'h00, 5'h00, 8'h12, 5'h01},
    {4'd11, 8'h81, 8'h00, 5'h1E, 8'h03, 5'h1F},
    {4'd12, 8'h81, 8'h00, 5'h00, 8'hC0, 5'h01},
    {4'd13, 8'h80, 8'h00, 5'h00, 8'h00, 5'h01},
    {4'd13, 8'h01, 8'h00, 5'h1F, 8'h03, 5'h1E},
    {4'd14, 8'h01, 8'h00, 5'h01, 8'h80, 5'h01},
    {4'd15, 8'h12, 8'h00, 5'h04, 8'h18, 5'h02}
  };

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [3:0] op = '0;
  logic [7:0] acc_in = '0, opnd_in = '0;
  logic [4:0] flags_in = '0;
  logic [7:0] res_out;
  logic [4:0] flags_out;
  logic out_valid;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_alu dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .acc_in(acc_in),
               .opnd_in(opnd_in), .flags_in(flags_in), .res_out(res_out),
               .flags_out(flags_out), .out_valid(out_valid));

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd0, 4'd1: return "R4";
      4'd2, 4'd3: return "R5";
      4'd4, 4'd5, 4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      4'd9, 4'd10: return "R9";
      4'd15: return "R11";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input logic [13:0] act, input logic [13:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got valid/res/flags=%h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    // R1 reset state
    check("R1", {out_valid, res_out, flags_out}, {1'b0, 8'h00, 5'h00});
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {op, acc_in, opnd_in, flags_in} = VEC[i][37:13];
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check(tag_of(VEC[i][37:34]), {out_valid, res_out, flags_out}, {1'b1, VEC[i][12:0]});
    end
    // R2 idle: inputs change with in_valid low, outputs hold and out_valid drops
    op = 4'd8; acc_in = 8'h55; flags_in = 5'h1F;
    @(negedge clk);
    @(negedge clk);
    check("R2", {out_valid, res_out, flags_out}, {1'b0, 8'h18, 5'h02});
    // R3 sign/zero/parity: 0x7F+0x01=0x80 -> S=1 Z=0 AC=1 P=0 CY=0
    op = 4'd0; acc_in = 8'h7F; opnd_in = 8'h01; flags_in = 5'h00; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R3", {out_valid, res_out, flags_out}, {1'b1, 8'h80, 5'h14});
    // R11 decimal adjust with carry in: 0x05, CY=1 -> 0x65, CY stays 1, P=1
    op = 4'd15; acc_in = 8'h05; flags_in = 5'h01; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R11", {out_valid, res_out, flags_out}, {1'b1, 8'h65, 5'h03});
    // R1 reset in mid-run clears outputs
    rst_n = 1'b0;
    #1;
    check("R1", {out_valid, res_out, flags_out}, {1'b0, 8'h00, 5'h00});
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule